// File: doc/BRIEF.md
# Contact Make/Break One-Shot Generator

This block turns a bouncing mechanical contact into exactly one clean pulse per qualified contact event. The raw contact goes through two debounce stages in series. Each stage follows its input only after the input has disagreed with the stage output for four consecutive sample ticks, so every stage lags its input by four ticks. The pulse comes from the gap between the two stage outputs, so its width is exactly four sample ticks and no width counter is needed.

The contact is open-high: closing it (make) pulls the line low. A select input chooses whether the pulse marks the make (high-to-low) or the break (low-to-high) of the contact. Both stage outputs are brought out as taps of a four-tick-spaced delay line, which other logic can use as timing references. All stages advance only on cycles where the shared sample tick enable is high. The pulse output is registered.

Top module: `mb_oneshot`

## Requirements
- R1: While reset is high and on the first clock after it, both taps read 1 (open contact) and the pulse output reads 0.
- R2: A tap changes only to the value of its input; it takes that value at the fourth consecutive tick on which its input differed from it, and a tick on which the input equals the tap restarts the count.
- R3: An input excursion lasting fewer than four ticks changes neither tap and produces no pulse.
- R4: Tap B has tap A as its input, so on a clean transition tap B changes four ticks after tap A.
- R5: With the edge select at 0 (make), the pulse is high when tap A is 0 and tap B is 1.
- R6: With the edge select at 1 (break), the pulse is high when tap A is 1 and tap B is 0.
- R7: One qualified transition in the selected direction gives exactly one pulse, lasting four tick periods; a transition in the other direction gives none.
- R8: On clock cycles with the tick enable low, neither tap changes.
- R9: The pulse output is a register: its value at a clock edge is computed from the taps and edge select just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Sample tick enable shared by both stages |
| contact_in | input | 1 | Raw contact level, 0 when closed |
| brk_sel | input | 1 | Edge select: 0 pulse on make, 1 pulse on break |
| pulse_o | output | 1 | Registered one-shot pulse |
| tap_a_o | output | 1 | First stage output (four-tick lag) |
| tap_b_o | output | 1 | Second stage output (eight-tick lag) |

## Verification
The assertions check on every cycle that a tap holds still without a tick, that any tap change lands on the value its input had, that the pulse is only ever high after the two taps disagreed, and that reset clears the pulse and sets the taps. Only the bench scenarios can show that short bounces are swallowed, that the pulse is exactly four tick periods wide, that only the selected edge produces it, and that one contact event produces one pulse; these are compared against a queue-based model on every clock.

// File: rtl/mb_oneshot_pkg.sv
package mb_oneshot_pkg;

    // number of debounce stages in the delay line
    localparam int NUM_STAGES = 2;

    typedef enum logic {
        EDGE_MAKE  = 1'b0,
        EDGE_BREAK = 1'b1
    } edge_sel_e;

    // lead = earlier tap, lag = later tap
    typedef struct packed {
        logic lead;
        logic lag;
    } tap_pair_t;

    // Make: NOR(lead, ~lag); break: NOR(~lead, lag)
    function automatic logic pulse_of(edge_sel_e mode, tap_pair_t t);
        logic p;
        if (mode == EDGE_MAKE) p = ~(t.lead | ~t.lag);
        else                   p = ~(~t.lead | t.lag);
        return p;
    endfunction

endpackage

// File: rtl/mb_deb_stage.sv
module mb_deb_stage #(
    parameter int DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(DEB_TICKS + 1);

    logic [CW-1:0] run_cnt;
    logic          level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b1;
            run_cnt <= '0;
        end else if (tick_en) begin
            if (din == level_q) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(DEB_TICKS - 1)) begin
                level_q <= din;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign dout = level_q;

    // R8
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(dout));

    // R2
    take_input_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> (dout == $past(din)));

endmodule

// File: rtl/mb_pulse_former.sv
module mb_pulse_former
    import mb_oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_sel_e mode,
    input  tap_pair_t taps,
    output logic      pulse
);
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= pulse_of(mode, taps);
    end

    assign pulse = pulse_q;

    // R9
    pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(taps.lead != taps.lag));

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> !pulse);

endmodule

// File: rtl/mb_oneshot.sv
module mb_oneshot
    import mb_oneshot_pkg::*;
#(
    parameter int DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic contact_in,
    input  logic brk_sel,
    output logic pulse_o,
    output logic tap_a_o,
    output logic tap_b_o
);
    // line[0] is the raw contact, line[k] the output of stage k
    logic [NUM_STAGES:0] line;
    tap_pair_t           pair;
    edge_sel_e           mode;

    assign line[0] = contact_in;

    generate
        for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
            mb_deb_stage #(.DEB_TICKS(DEB_TICKS)) u_stage (
                .clk     (clk),
                .rst     (rst),
                .tick_en (tick_en),
                .din     (line[k]),
                .dout    (line[k+1])
            );
        end
    endgenerate

    assign pair.lead = line[1];
    assign pair.lag  = line[2];
    assign mode      = edge_sel_e'(brk_sel);

    mb_pulse_former u_former (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .taps  (pair),
        .pulse (pulse_o)
    );

    assign tap_a_o = line[1];
    assign tap_b_o = line[2];

    // R1
    rst_taps_chk: assert property (@(posedge clk)
        rst |=> (tap_a_o && tap_b_o));

    // R4
    b_follows_a_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tap_b_o) |-> (tap_b_o == $past(tap_a_o)));

endmodule

// File: tb/mb_oneshot_tb_top.sv
module mb_oneshot_tb_top;
    localparam int TICK_PER = 3;
    localparam int DEB      = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic contact_in = 1'b1;
    logic brk_sel = 1'b0;
    logic pulse_o, tap_a_o, tap_b_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mb_oneshot #(.DEB_TICKS(DEB)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .contact_in(contact_in),
        .brk_sel(brk_sel), .pulse_o(pulse_o), .tap_a_o(tap_a_o), .tap_b_o(tap_b_o)
    );

    // ---------------- behavioural reference ----------------
    bit ref_a = 1, ref_b = 1, ref_p = 0;
    bit hist_a[$];
    bit hist_b[$];

    function automatic bit all_differ(bit h[$], bit cur);
        if (h.size() < DEB) return 0;
        foreach (h[i]) if (h[i] == cur) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        bit na, nb;
        if (rst) begin
            ref_a = 1; ref_b = 1; ref_p = 0;
            hist_a.delete(); hist_b.delete();
        end else begin
            ref_p = brk_sel ? (ref_a && !ref_b) : (!ref_a && ref_b);
            na = ref_a; nb = ref_b;
            if (tick_en) begin
                hist_b.push_back(ref_a);
                if (hist_b.size() > DEB) void'(hist_b.pop_front());
                if (all_differ(hist_b, ref_b)) nb = ref_a;
                hist_a.push_back(contact_in);
                if (hist_a.size() > DEB) void'(hist_a.pop_front());
                if (all_differ(hist_a, ref_a)) na = contact_in;
            end
            ref_a = na; ref_b = nb;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison and pulse statistics
    int pulse_count = 0;
    int run_len = 0;
    int last_width = 0;
    bit prev_p = 0;

    always @(negedge clk) begin
        if (!rst) begin
            check("R2 tap A", tap_a_o, ref_a);
            check("R4 tap B", tap_b_o, ref_b);
            check(brk_sel ? "R6/R9 pulse" : "R5/R9 pulse", pulse_o, ref_p);
            if (pulse_o) run_len++;
            if (pulse_o && !prev_p) pulse_count++;
            if (!pulse_o && prev_p) begin last_width = run_len; run_len = 0; end
            prev_p = pulse_o;
        end
    end

    // tick generator
    bit tick_run = 1;
    int phase = 0;
    always @(negedge clk) begin
        if (tick_run && !rst) begin
            phase = (phase + 1) % TICK_PER;
            tick_en <= (phase == 0);
        end else begin
            tick_en <= 1'b0;
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit ha, hb;
        wait_clk(3);
        // R1: reset state
        check("R1 tap A in reset", tap_a_o, 1);
        check("R1 tap B in reset", tap_b_o, 1);
        check("R1 pulse in reset", pulse_o, 0);
        rst = 0;
        wait_clk(1);
        check("R1 tap A after reset", tap_a_o, 1);
        check("R1 pulse after reset", pulse_o, 0);
        wait_clk(40);

        // R3: bounces shorter than four ticks
        pulse_count = 0;
        for (int k = 1; k < DEB; k++) begin
            contact_in = 0; wait_clk(k * TICK_PER);
            contact_in = 1; wait_clk(2 * TICK_PER);
        end
        wait_clk(40);
        check("R3 no pulse on short bounce", pulse_count, 0);
        check("R3 tap A unchanged", tap_a_o, 1);
        check("R3 tap B unchanged", tap_b_o, 1);

        // R5/R7: clean make in make mode
        pulse_count = 0;
        contact_in = 0; wait_clk(3);
        contact_in = 1; wait_clk(3);
        contact_in = 0;
        wait_clk(80);
        check("R7 one pulse on make", pulse_count, 1);
        check("R7 make pulse width", last_width, DEB * TICK_PER);
        check("R4 tap B settled low", tap_b_o, 0);

        // R6/R7: break mode, pulse on release
        brk_sel = 1;
        wait_clk(5);
        pulse_count = 0;
        contact_in = 1; wait_clk(2);
        contact_in = 0; wait_clk(2);
        contact_in = 1;
        wait_clk(80);
        check("R6 one pulse on break", pulse_count, 1);
        check("R7 break pulse width", last_width, DEB * TICK_PER);

        // R7: make while in break mode gives no pulse
        pulse_count = 0;
        contact_in = 0;
        wait_clk(80);
        check("R7 no pulse on unselected edge", pulse_count, 0);
        check("R4 tap A low after make", tap_a_o, 0);

        // R8: ticks stopped, taps frozen
        tick_run = 0;
        wait_clk(2);
        ha = tap_a_o; hb = tap_b_o;
        contact_in = 1;
        wait_clk(60);
        check("R8 tap A frozen", tap_a_o, ha);
        check("R8 tap B frozen", tap_b_o, hb);
        tick_run = 1;
        wait_clk(80);
        check("R8 tap A resumes", tap_a_o, 1);

        // R5: back to make mode, repeat make once more
        brk_sel = 0;
        wait_clk(5);
        pulse_count = 0;
        contact_in = 0;
        wait_clk(80);
        check("R5 make pulse again", pulse_count, 1);

        finish_run();
    end
endmodule